// File: doc/BRIEF.md
# ATM Cell Transmit Processor

This block produces an unbroken byte-wide stream of 53-byte ATM cells for a transmit line. At every cell boundary it either begins forwarding a user cell offered on its input handshake or, when no cell is offered, generates a fill cell on its own. The fill cell can be an idle cell or an unassigned cell, chosen by a control bit. For every outgoing cell, user or fill, the block computes the header error check byte, adds the coset to it and places it in the fifth header octet.

A control bit sets how user cells arrive. In insert mode the upstream queue supplies 52 bytes per cell and the block opens a slot for the check byte. In overwrite mode the queue supplies all 53 bytes and the fifth octet it sends is thrown away. A second control bit enables a self-synchronizing x^43+1 scrambler, which acts on the 48 payload octets of every cell and leaves the header alone. The scrambler state runs on from one cell to the next.

The upstream source must keep `in_valid` high for the whole of a cell once it has been accepted. Control inputs are expected to change only while reset is asserted.

Top module: `atm_cell_tx`

## Requirements
- R1: After reset is released, `out_valid` goes high and stays high. `out_soc` marks the first header byte of each cell and repeats every 53 cycles, so cells follow each other with no gap. The first valid byte carries `out_soc`.
- R2: A user cell begins only when `in_valid` and `in_sop` are both high at a cell boundary. From then on the block takes one input byte in each cycle it asserts `in_ready`, and it sends header bytes 0 to 3 and all 48 payload bytes in the order they arrived.
- R3: If `in_valid` is high without `in_sop` at a cell boundary, that byte is accepted and discarded, and a fill cell is sent in that slot.
- R4: When no user cell starts, a fill cell is sent with payload bytes of 0x6A. Its header is 00 00 00 01 when `cfg_fill_unassigned`=0 and 00 00 00 00 when it is 1.
- R5: Output byte 4 of every cell holds CRC-8 XOR 0x55. The CRC uses polynomial x^8+x^2+x+1 with initial value 0, taken over header bytes 0 to 3 MSB first. This gives 0x52 for the idle fill cell and 0x55 for the unassigned fill cell.
- R6: With `cfg_hec_overwrite`=0 a user cell takes 52 input bytes, and `in_ready` stays low during the check-byte slot.
- R7: With `cfg_hec_overwrite`=1 a user cell takes 53 input bytes. Input byte 4 is consumed and replaced by the computed check byte.
- R8: With `cfg_scr_en`=1 each payload bit, taken MSB first, leaves XORed with the scrambled bit sent 43 payload bits earlier. Header bytes are never scrambled, and the history runs across cells of both kinds.
- R9: Reset loads the scrambler history with all ones, so the first five payload bytes after reset leave inverted (0x6A becomes 0x95 for a fill cell).
- R10: With `cfg_scr_en`=0 payload bytes leave unchanged.
- R11: While reset is asserted, `out_valid` and `in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte offered |
| in_sop | input | 1 | Offered byte is the first byte of a cell |
| in_data | input | 8 | Input cell byte |
| in_ready | output | 1 | Offered byte is taken at this clock edge |
| cfg_hec_overwrite | input | 1 | 1: input cells carry 53 bytes and byte 4 is replaced; 0: 52 bytes and the check byte is inserted |
| cfg_scr_en | input | 1 | Enable payload scrambling |
| cfg_fill_unassigned | input | 1 | Fill cell type: 0 idle, 1 unassigned |
| out_valid | output | 1 | Output byte stream running |
| out_soc | output | 1 | First header byte of a cell |
| out_data | output | 8 | Output cell byte |

## Verification
A slip in the byte-position counter shows at the ports within one cell. It either moves `out_soc` off its 53-cycle spacing or misaligns the header, so byte 4 no longer matches the CRC of bytes 0 to 3. A corrupt CRC register is visible in the check byte of the same cell. A wrong scrambler state appears in the first payload byte that depends on it. The bench descrambles with its own history, seeded the same way, so it catches that error exactly rather than after the descrambler resynchronizes. A wrong user/fill decision appears at the next boundary as a missing, extra or misplaced user cell.

// File: rtl/atm_tx_pkg.sv
package atm_tx_pkg;

    localparam int CELL_BYTES = 53;
    localparam int HEC_IDX    = 4;
    localparam int POS_W      = $clog2(CELL_BYTES);
    localparam int SCR_LEN    = 43;
    localparam int BYTE_W     = 8;

    localparam logic [POS_W-1:0] POS_LAST = POS_W'(CELL_BYTES - 1);
    localparam logic [POS_W-1:0] POS_HEC  = POS_W'(HEC_IDX);

    typedef enum logic [1:0] {
        SEG_HDR,
        SEG_HEC,
        SEG_PAY
    } seg_e;

    typedef struct packed {
        logic [POS_W-1:0] pos;
        seg_e             seg;
        logic             user;
        logic             first;
    } slot_t;

    typedef struct packed {
        logic [SCR_LEN-1:0] st;
        logic [BYTE_W-1:0]  q;
    } scr_res_t;

    // One byte through the CRC-8 (x^8+x^2+x+1) register, MSB first.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] d);
        logic [7:0] c;
        c = crc ^ d;
        for (int i = 0; i < 8; i++) begin
            c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c;
    endfunction

    // One byte through the self-synchronizing x^43+1 scrambler, MSB first.
    function automatic scr_res_t scr_step(input logic [SCR_LEN-1:0] st, input logic [BYTE_W-1:0] d);
        scr_res_t r;
        r.st = st;
        r.q  = '0;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            r.q[i] = d[i] ^ r.st[SCR_LEN-1];
            r.st   = {r.st[SCR_LEN-2:0], r.q[i]};
        end
        return r;
    endfunction

endpackage

// File: rtl/atm_tx_seq.sv
module atm_tx_seq
    import atm_tx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  logic  in_sop,
    input  logic  cfg_hec_overwrite,
    output slot_t slot,
    output logic  in_ready
);

    logic [POS_W-1:0] pos_q;
    logic             user_q;
    logic             at_boundary;
    logic             start;
    seg_e             seg;

    assign at_boundary = (pos_q == '0);
    assign start       = at_boundary && in_valid && in_sop;

    always_comb begin
        if (pos_q < POS_HEC)       seg = SEG_HDR;
        else if (pos_q == POS_HEC) seg = SEG_HEC;
        else                       seg = SEG_PAY;
    end

    assign slot.pos   = pos_q;
    assign slot.seg   = seg;
    assign slot.user  = at_boundary ? start : user_q;
    assign slot.first = at_boundary;

    always_comb begin
        if (rst)              in_ready = 1'b0;
        else if (at_boundary) in_ready = in_valid;
        else                  in_ready = user_q && ((seg != SEG_HEC) || cfg_hec_overwrite);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            user_q <= 1'b0;
        end else begin
            pos_q <= (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
            if (at_boundary) user_q <= start;
        end
    end

endmodule

// File: rtl/atm_tx_hec.sv
module atm_tx_hec
    import atm_tx_pkg::*;
#(
    parameter logic [7:0] COSET = 8'h55
) (
    input  logic       clk,
    input  logic       rst,
    input  slot_t      slot,
    input  logic [7:0] hdr_byte,
    output logic [7:0] hec
);

    logic [7:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= '0;
        end else if (slot.seg == SEG_HDR) begin
            crc_q <= crc8_step(slot.first ? 8'h00 : crc_q, hdr_byte);
        end
    end

    assign hec = crc_q ^ COSET;

endmodule

// File: rtl/atm_tx_scr.sv
module atm_tx_scr
    import atm_tx_pkg::*;
#(
    parameter logic [SCR_LEN-1:0] SEED = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout
);

    logic [SCR_LEN-1:0] st_q;
    scr_res_t           res;

    assign res  = scr_step(st_q, din);
    assign dout = en ? res.q : din;

    always_ff @(posedge clk) begin
        if (rst)     st_q <= SEED;
        else if (en) st_q <= res.st;
    end

endmodule

// File: rtl/atm_cell_tx.sv
module atm_cell_tx
    import atm_tx_pkg::*;
#(
    parameter logic [7:0]         HEC_COSET  = 8'h55,
    parameter logic [7:0]         FILL_OCTET = 8'h6A,
    parameter logic [SCR_LEN-1:0] SCR_SEED   = '1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_sop,
    input  logic [7:0] in_data,
    output logic       in_ready,
    input  logic       cfg_hec_overwrite,
    input  logic       cfg_scr_en,
    input  logic       cfg_fill_unassigned,
    output logic       out_valid,
    output logic       out_soc,
    output logic [7:0] out_data
);

    slot_t      slot;
    logic [7:0] fill_byte;
    logic [7:0] raw_byte;
    logic [7:0] hec;
    logic [7:0] pre_byte;
    logic [7:0] scr_byte;

    atm_tx_seq u_seq (
        .clk               (clk),
        .rst               (rst),
        .in_valid          (in_valid),
        .in_sop            (in_sop),
        .cfg_hec_overwrite (cfg_hec_overwrite),
        .slot              (slot),
        .in_ready          (in_ready)
    );

    // Fill cell: header 00 00 00 01 (idle) or all zero (unassigned).
    always_comb begin
        if (slot.seg == SEG_PAY)
            fill_byte = FILL_OCTET;
        else if (slot.pos == POS_W'(HEC_IDX - 1))
            fill_byte = {7'b0, ~cfg_fill_unassigned};
        else
            fill_byte = 8'h00;
    end

    assign raw_byte = slot.user ? in_data : fill_byte;

    atm_tx_hec #(.COSET(HEC_COSET)) u_hec (
        .clk      (clk),
        .rst      (rst),
        .slot     (slot),
        .hdr_byte (raw_byte),
        .hec      (hec)
    );

    assign pre_byte = (slot.seg == SEG_HEC) ? hec : raw_byte;

    atm_tx_scr #(.SEED(SCR_SEED)) u_scr (
        .clk  (clk),
        .rst  (rst),
        .en   (cfg_scr_en && (slot.seg == SEG_PAY)),
        .din  (pre_byte),
        .dout (scr_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_soc   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b1;
            out_soc   <= slot.first;
            out_data  <= scr_byte;
        end
    end

endmodule

// File: rtl/atm_cell_tx_chk.sv
module atm_cell_tx_chk
    import atm_tx_pkg::*;
#(
    parameter logic [7:0] HEC_COSET = 8'h55
) (
    input logic       clk,
    input logic       rst,
    input logic       out_valid,
    input logic       out_soc,
    input logic [7:0] out_data,
    input logic       in_ready,
    input logic       cfg_hec_overwrite,
    input slot_t      seq_slot
);

    logic [POS_W-1:0] cnt;
    logic             seen;
    logic [7:0]       ccrc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            seen <= 1'b0;
            ccrc <= '0;
        end else if (out_valid) begin
            if (out_soc) begin
                cnt  <= '0;
                seen <= 1'b1;
                ccrc <= crc8_step(8'h00, out_data);
            end else begin
                cnt <= cnt + 1'b1;
                if (cnt <= POS_W'(2)) ccrc <= crc8_step(ccrc, out_data);
            end
        end
    end

    p_valid_hold_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> out_valid);

    p_first_soc_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> out_soc);

    p_soc_spacing_r1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && seen && out_soc) |-> (cnt == POS_W'(CELL_BYTES - 1)));

    p_no_early_soc_r1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && seen && !out_soc) |-> (cnt != POS_W'(CELL_BYTES - 1)));

    p_hec_value_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && seen && !out_soc && cnt == POS_W'(HEC_IDX - 1))
            |-> (out_data == (ccrc ^ HEC_COSET)));

    p_hec_slot_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (!cfg_hec_overwrite && seq_slot.seg == SEG_HEC) |-> !in_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            p_reset_quiet_r11: assert (!in_ready);
        end
    end

endmodule

bind atm_cell_tx atm_cell_tx_chk #(.HEC_COSET(HEC_COSET)) u_chk (
    .clk               (clk),
    .rst               (rst),
    .out_valid         (out_valid),
    .out_soc           (out_soc),
    .out_data          (out_data),
    .in_ready          (in_ready),
    .cfg_hec_overwrite (cfg_hec_overwrite),
    .seq_slot          (slot)
);

// File: tb/atm_cell_tx_tb.sv
module atm_cell_tx_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_sop = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready;
    logic       cfg_hec_overwrite = 1'b0;
    logic       cfg_scr_en = 1'b0;
    logic       cfg_fill_unassigned = 1'b0;
    logic       out_valid;
    logic       out_soc;
    logic [7:0] out_data;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    atm_cell_tx u_dut (
        .clk (clk), .rst (rst),
        .in_valid (in_valid), .in_sop (in_sop), .in_data (in_data), .in_ready (in_ready),
        .cfg_hec_overwrite (cfg_hec_overwrite), .cfg_scr_en (cfg_scr_en),
        .cfg_fill_unassigned (cfg_fill_unassigned),
        .out_valid (out_valid), .out_soc (out_soc), .out_data (out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference CRC, written as a bit-serial LFSR.
    function automatic logic [7:0] ref_crc(input logic [31:0] hdr);
        logic [7:0] c = 8'h00;
        for (int i = 31; i >= 0; i--) begin
            logic fb = c[7] ^ hdr[i];
            c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return c;
    endfunction

    // Expected user cells, as header and payload base (payload byte k = base + 3k).
    logic [31:0] exp_hdr[$];
    logic [7:0]  exp_base[$];

    // Output monitor and descrambling model.
    logic [7:0]  cbuf [53];
    int          idx;
    logic [42:0] ds;
    int          fill_cells;
    int          user_cells;
    bit          first_cell;

    always @(negedge clk) begin
        if (rst) begin
            idx        = -1;
            ds         = '1;
            first_cell = 1;
        end else if (out_valid) begin
            if (out_soc) begin
                if (idx != -1)
                    chk(idx == 52, "R1", "soc spacing", idx, 52);
                idx = 0;
            end else if (idx >= 0) begin
                idx++;
            end
            if (idx >= 0 && idx <= 52) cbuf[idx] = out_data;
            if (idx == 52) process_cell();
            if (idx > 52) begin
                chk(0, "R1", "missing soc", idx, 52);
                idx = -1;
            end
        end
    end

    task automatic process_cell();
        logic [31:0] hdr;
        logic [7:0]  pay [48];
        logic [31:0] fill_hdr;
        bit          ok;
        hdr = {cbuf[0], cbuf[1], cbuf[2], cbuf[3]};
        chk(cbuf[4] == (ref_crc(hdr) ^ 8'h55), "R5", "check byte", cbuf[4], ref_crc(hdr) ^ 8'h55);
        if (first_cell && cfg_scr_en)
            chk(cbuf[5] == 8'h95, "R9", "first payload after reset", cbuf[5], 8'h95);
        first_cell = 0;
        for (int k = 0; k < 48; k++) begin
            if (cfg_scr_en) begin
                for (int b = 7; b >= 0; b--) begin
                    logic s = cbuf[5+k][b];
                    pay[k][b] = s ^ ds[42];
                    ds = {ds[41:0], s};
                end
            end else begin
                pay[k] = cbuf[5+k];
            end
        end
        fill_hdr = cfg_fill_unassigned ? 32'h0000_0000 : 32'h0000_0001;
        if (hdr == fill_hdr) begin
            fill_cells++;
            ok = 1;
            for (int k = 0; k < 48; k++) if (pay[k] != 8'h6A) ok = 0;
            chk(ok, cfg_scr_en ? "R8" : "R4", "fill payload", pay[0], 8'h6A);
            chk(cbuf[4] == (cfg_fill_unassigned ? 8'h55 : 8'h52), "R4", "fill check byte",
                cbuf[4], cfg_fill_unassigned ? 8'h55 : 8'h52);
        end else if (exp_hdr.size() == 0) begin
            chk(0, "R3", "unexpected user cell", hdr, fill_hdr);
        end else begin
            logic [31:0] eh = exp_hdr.pop_front();
            logic [7:0]  eb = exp_base.pop_front();
            user_cells++;
            chk(hdr == eh, cfg_hec_overwrite ? "R7" : "R6", "user header", hdr, eh);
            ok = 1;
            for (int k = 0; k < 48; k++) if (pay[k] != 8'(eb + 3*k)) ok = 0;
            chk(ok, cfg_scr_en ? "R8" : "R10", "user payload", pay[47], 8'(eb + 141));
        end
    endtask

    task automatic do_reset(input bit ovr, input bit scr, input bit unas);
        @(negedge clk);
        rst = 1; in_valid = 0; in_sop = 0;
        cfg_hec_overwrite = ovr; cfg_scr_en = scr; cfg_fill_unassigned = unas;
        exp_hdr.delete(); exp_base.delete();
        repeat (3) @(negedge clk);
        in_valid = 1; in_sop = 1;
        #1;
        chk(!out_valid && !in_ready, "R11", "quiet in reset", {out_valid, in_ready}, 0);
        in_valid = 0; in_sop = 0;
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(out_valid && out_soc, "R1", "first byte after reset", {out_valid, out_soc}, 2'b11);
    endtask

    task automatic send_cell(input logic [31:0] hdr, input logic [7:0] base);
        logic [7:0] b [53];
        int n;
        for (int i = 0; i < 4; i++) b[i] = hdr[31-8*i -: 8];
        if (cfg_hec_overwrite) begin
            b[4] = 8'hEE;
            for (int k = 0; k < 48; k++) b[5+k] = 8'(base + 3*k);
            n = 53;
        end else begin
            for (int k = 0; k < 48; k++) b[4+k] = 8'(base + 3*k);
            n = 52;
        end
        exp_hdr.push_back(hdr);
        exp_base.push_back(base);
        for (int i = 0; i < n; ) begin
            @(negedge clk);
            in_valid = 1; in_sop = (i == 0); in_data = b[i];
            #1;
            if (in_ready) i++;
        end
        @(negedge clk);
        in_valid = 0; in_sop = 0;
    endtask

    typedef struct packed {
        logic [31:0] hdr;
        logic [7:0]  base;
        logic        ovr;
        logic        scr;
        logic        unas;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{hdr: 32'h1234_5670, base: 8'h01, ovr: 1'b0, scr: 1'b0, unas: 1'b0},
        '{hdr: 32'hFFFF_FFF0, base: 8'h80, ovr: 1'b1, scr: 1'b0, unas: 1'b1},
        '{hdr: 32'h0A0B_0C0D, base: 8'h6A, ovr: 1'b0, scr: 1'b1, unas: 1'b0},
        '{hdr: 32'h8000_0002, base: 8'hF0, ovr: 1'b1, scr: 1'b1, unas: 1'b1},
        '{hdr: 32'h0000_0010, base: 8'h00, ovr: 1'b0, scr: 1'b1, unas: 1'b1},
        '{hdr: 32'hDEAD_BEE0, base: 8'h55, ovr: 1'b1, scr: 1'b0, unas: 1'b0}
    };

    initial begin
        fill_cells = 0;
        user_cells = 0;
        for (int v = 0; v < NV; v++) begin
            int uc0;
            do_reset(VEC[v].ovr, VEC[v].scr, VEC[v].unas);
            repeat (20 + 7*v) @(negedge clk);
            uc0 = user_cells;
            send_cell(VEC[v].hdr, VEC[v].base);
            send_cell(VEC[v].hdr ^ 32'h0100_0000, VEC[v].base + 8'd7);
            repeat (2*53 + 10) @(negedge clk);
            chk(exp_hdr.size() == 0 && user_cells == uc0 + 2, "R2", "user cells delivered",
                user_cells - uc0, 2);
        end

        // R3: a stray byte without start mark at a boundary is dropped.
        begin
            int fc0, uc0;
            bit seen_ready = 0;
            do_reset(1'b0, 1'b1, 1'b0);
            repeat (10) @(negedge clk);
            fc0 = fill_cells; uc0 = user_cells;
            while (!seen_ready) begin
                @(negedge clk);
                in_valid = 1; in_sop = 0; in_data = 8'h33;
                #1;
                seen_ready = in_ready;
            end
            @(negedge clk);
            in_valid = 0;
            repeat (3*53) @(negedge clk);
            chk(user_cells == uc0, "R3", "no user cell from stray byte", user_cells - uc0, 0);
            chk(fill_cells >= fc0 + 2, "R3", "fill cells continue", fill_cells - fc0, 2);
        end

        // R2: valid held low keeps in_ready low at a boundary.
        begin
            bit rdy = 0;
            for (int c = 0; c < 60; c++) begin
                @(negedge clk); #1;
                if (in_ready) rdy = 1;
            end
            chk(!rdy, "R2", "no acceptance without valid", rdy, 0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule